// File: doc/BRIEF.md
# Operating-System Timer with Watchdog Compare

This peripheral keeps a 32-bit up-counter that advances by one on each tick enable pulse and wraps to zero after its top value. Four compare registers sit beside it. When a tick moves the counter onto a compare value and that channel's interrupt enable is set, the channel raises a sticky status flag. The flag drives a dedicated interrupt line towards an external interrupt controller. Software clears the flag by writing a one to it.

The last compare channel also works as a watchdog. Software can arm the watchdog with a single write, and only a reset can disarm it. While it is armed, a tick that lands the counter on the last compare value produces a one-cycle reset-request pulse. This happens whether or not that channel's interrupt enable is set.

Software reaches every register through a simple word-addressed register bus. The bus has a write strobe, an address and write data, and returns read data combinationally. The address bits below bit 2 are ignored. The register map is:

| Offset | Register |
|---|---|
| 0x00, 0x04, 0x08, 0x0C | Compare registers 0 to 3 |
| 0x10 | Counter |
| 0x14 | Status |
| 0x18 | Watchdog arm |
| 0x1C | Interrupt enable |

Top module: `ost_timer`

## Requirements
- R1: The counter (offset 0x10) rises by exactly one at each clock edge where `tick_en` is high. It holds its value when `tick_en` is low. It wraps from 0xFFFFFFFF to 0x00000000.
- R2: A bus write to the counter loads the written value. If the write falls in the same cycle as a tick, the write wins and that cycle produces no match.
- R3: Compare registers 0 to 3 sit at byte offsets 0x00, 0x04, 0x08 and 0x0C. Each one reads back the full 32-bit value last written.
- R4: Status bit i (offset 0x14) sets at the clock edge where a tick moves the counter onto compare register i, if bit i of the interrupt-enable register is 1. It does not set if that enable bit is 0. This includes a match on the wrap to zero.
- R5: A match is recognised only on the tick that brings the counter to the compare value. If the counter stays equal to the compare value without ticking, a cleared status bit is not set again.
- R6: Writing 1 to status bit i clears it, and writing 0 leaves it unchanged. If a clear and a new match on the same bit fall in the same cycle, the bit stays set.
- R7: Output `irq[i]` always equals status bit i.
- R8: The watchdog-arm register (offset 0x18) holds only bit 0, and bits 31:1 read as zero. Writing 1 to bit 0 sets it. Writing 0 has no effect. Only a reset clears it.
- R9: `rst_req` is high for exactly one cycle, in the cycle after a tick lands the counter on compare register 3 while the watchdog is armed. This does not depend on interrupt-enable bit 3. `rst_req` never rises while the watchdog is disarmed.
- R10: The interrupt-enable register (offset 0x1C) keeps bits 3:0, and its upper bits read as zero.
- R11: After reset, every register reads zero and `irq` and `rst_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance enable, one per timer tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte address; bits 1:0 ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 4 | Per-channel interrupt lines, one per status bit |
| rst_req | output | 1 | One-cycle system reset request from the watchdog channel |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is a software clear of a status bit and a tick that creates a new match on that same bit. The bench provokes it by asserting `tick_en` in the same cycle as the write-one-to-clear, with the counter one step below the compare value. It judges the outcome by reading status afterwards: the bit must still be set.

The second pair is a counter write and a tick. The bench drives both together and checks two things: the written value must survive unincremented, and no status flag may appear even when the written value equals an enabled compare value.

// File: rtl/ost_pkg.sv
package ost_pkg;

    // Register groups seen on the bus
    typedef enum logic [2:0] {
        SEL_CMP  = 3'd0,
        SEL_CNT  = 3'd1,
        SEL_STAT = 3'd2,
        SEL_WDOG = 3'd3,
        SEL_IEN  = 3'd4,
        SEL_NONE = 3'd5
    } reg_sel_e;

    // Decoded bus command
    typedef struct packed {
        logic     we;
        reg_sel_e sel;
    } bus_cmd_t;

    // Word index -> register group; compare words first, then the four control words
    function automatic reg_sel_e sel_of(input int unsigned word, input int unsigned nch);
        reg_sel_e s;
        if (word < nch) begin
            s = SEL_CMP;
        end else begin
            case (word - nch)
                0:       s = SEL_CNT;
                1:       s = SEL_STAT;
                2:       s = SEL_WDOG;
                3:       s = SEL_IEN;
                default: s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/ost_counter.sv
module ost_counter #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          ld,
    input  logic [DW-1:0] ld_val,
    output logic [DW-1:0] cnt,
    output logic [DW-1:0] cnt_nxt,
    output logic          adv
);
    assign cnt_nxt = cnt + 1'b1;
    assign adv     = tick & ~ld;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (tick) begin
            cnt <= cnt_nxt;
        end
    end
endmodule

// File: rtl/ost_channel.sv
module ost_channel #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_cmp,
    input  logic [DW-1:0] wdata,
    input  logic          adv,
    input  logic [DW-1:0] cnt_nxt,
    input  logic          ien,
    input  logic          clr,
    output logic [DW-1:0] cmp,
    output logic          evt,
    output logic          stat
);
    // Event only when a tick carries the counter onto the compare value
    assign evt = adv && (cnt_nxt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp  <= '0;
            stat <= 1'b0;
        end else begin
            if (wr_cmp) cmp <= wdata;
            stat <= (evt & ien) | (stat & ~clr);
        end
    end
endmodule

// File: rtl/ost_watchdog.sv
module ost_watchdog (
    input  logic clk,
    input  logic rst,
    input  logic arm_wr,
    input  logic arm_bit,
    input  logic evt,
    output logic armed,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            req   <= 1'b0;
        end else begin
            if (arm_wr && arm_bit) armed <= 1'b1;
            req <= armed & evt;
        end
    end
endmodule

// File: rtl/ost_timer.sv
module ost_timer
    import ost_pkg::*;
#(
    parameter  int unsigned DW  = 32,
    parameter  int unsigned NCH = 4,
    localparam int unsigned AW  = $clog2((NCH + 4) * 4)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [NCH-1:0] irq,
    output logic          rst_req
);
    localparam int unsigned WW = AW - 2;

    logic [WW-1:0]  word;
    bus_cmd_t       cmd;
    logic [DW-1:0]  cnt_q;
    logic [DW-1:0]  cnt_nxt;
    logic           cnt_adv;
    logic           cnt_ld;
    logic [DW-1:0]  cmp_q [NCH];
    logic [NCH-1:0] evt;
    logic [NCH-1:0] stat;
    logic [NCH-1:0] ien_q;
    logic           wd_en;

    assign word    = addr[AW-1:2];
    assign cmd.we  = wr_en;
    assign cmd.sel = sel_of(32'(word), NCH);
    assign cnt_ld  = cmd.we && (cmd.sel == SEL_CNT);

    ost_counter #(.DW(DW)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick_en), .ld(cnt_ld), .ld_val(wdata),
        .cnt(cnt_q), .cnt_nxt(cnt_nxt), .adv(cnt_adv)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ost_channel #(.DW(DW)) u_ch (
            .clk(clk), .rst(rst),
            .wr_cmp(cmd.we && cmd.sel == SEL_CMP && word == WW'(i)),
            .wdata(wdata), .adv(cnt_adv), .cnt_nxt(cnt_nxt),
            .ien(ien_q[i]),
            .clr(cmd.we && cmd.sel == SEL_STAT && wdata[i]),
            .cmp(cmp_q[i]), .evt(evt[i]), .stat(stat[i])
        );
    end

    ost_watchdog u_wd (
        .clk(clk), .rst(rst),
        .arm_wr(cmd.we && cmd.sel == SEL_WDOG), .arm_bit(wdata[0]),
        .evt(evt[NCH-1]), .armed(wd_en), .req(rst_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= '0;
        end else if (cmd.we && cmd.sel == SEL_IEN) begin
            ien_q <= wdata[NCH-1:0];
        end
    end

    assign irq = stat;

    always_comb begin
        rdata = '0;
        case (cmd.sel)
            SEL_CMP: begin
                for (int i = 0; i < NCH; i++) begin
                    if (word == WW'(i)) rdata = cmp_q[i];
                end
            end
            SEL_CNT:  rdata = cnt_q;
            SEL_STAT: rdata[NCH-1:0] = stat;
            SEL_WDOG: rdata[0] = wd_en;
            SEL_IEN:  rdata[NCH-1:0] = ien_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/ost_timer_sva.sv
module ost_timer_sva #(
    parameter int unsigned DW  = 32,
    parameter int unsigned NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           tick_en,
    input logic [NCH-1:0] irq,
    input logic           rst_req,
    input logic           wd_en,
    input logic [DW-1:0]  cnt,
    input logic           cnt_load
);
    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !cnt_load) |=> cnt == ($past(cnt) + 1'b1));

    assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !cnt_load) |=> $stable(cnt));

    assert_wd_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        wd_en |=> wd_en);

    assert_req_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    assert_req_armed_R9: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> wd_en);

    for (genvar i = 0; i < NCH; i++) begin : g_irq
        assert_irq_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[i]) |-> $past(tick_en));
    end
endmodule

bind ost_timer ost_timer_sva #(.DW(DW), .NCH(NCH)) u_sva (
    .clk(clk), .rst(rst), .tick_en(tick_en), .irq(irq), .rst_req(rst_req),
    .wd_en(wd_en), .cnt(cnt_q), .cnt_load(cnt_ld)
);

// File: tb/ost_timer_test.sv
module ost_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_CNT = 5'h10, A_STAT = 5'h14, A_WD = 5'h18, A_IE = 5'h1C;

    logic        clk = 0;
    logic        rst = 1;
    logic        tick_en = 0;
    logic        wr_en = 0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;
    logic        rst_req;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ost_timer uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_en = 1;
            @(negedge clk);
            tick_en = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();

        // R11: everything zero after reset
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), v);
            chk("R11 reg zero", v, 32'h0);
        end
        chk("R11 irq", {28'h0, irq}, 32'h0);
        chk("R11 rst_req", {31'h0, rst_req}, 32'h0);

        // R3: compare registers read back
        for (int i = 0; i < 4; i++) wr(5'(i * 4), 32'hA5C30000 ^ (32'h01010101 * i));
        for (int i = 0; i < 4; i++) begin
            rd(5'(i * 4), v);
            chk("R3 compare readback", v, 32'hA5C30000 ^ (32'h01010101 * i));
        end

        // R10: only low enable bits kept
        wr(A_IE, 32'hFFFFFFFF);
        rd(A_IE, v); chk("R10 ie upper zero", v, 32'hF);
        wr(A_IE, 32'h0);

        // R1: step, hold, wrap
        wr(A_CNT, 32'd100);
        tick(5);
        rd(A_CNT, v); chk("R1 counter steps", v, 32'd105);
        repeat (3) @(negedge clk);
        rd(A_CNT, v); chk("R1 counter holds", v, 32'd105);
        wr(A_CNT, 32'hFFFFFFFE);
        tick(2);
        rd(A_CNT, v); chk("R1 counter wraps", v, 32'h0);

        // R2: write wins over simultaneous tick, no match created
        wr(A_IE, 32'h1);
        wr(32'h0, 32'd500);
        @(negedge clk);
        wr_en = 1; addr = A_CNT; wdata = 32'd500; tick_en = 1;
        @(negedge clk);
        wr_en = 0; tick_en = 0;
        rd(A_CNT, v); chk("R2 write beats tick", v, 32'd500);
        rd(A_STAT, v); chk("R2 no match on load", v, 32'h0);

        // R4/R7: sweep every enable pattern
        for (int i = 0; i < 4; i++) wr(5'(i * 4), 32'd1000 + 32'(i));
        for (int m = 0; m < 16; m++) begin
            wr(A_IE, 32'(m));
            wr(A_CNT, 32'd999);
            tick(4);
            rd(A_STAT, v); chk("R4 status by enable", v, 32'(m));
            chk("R7 irq mirrors status", {28'h0, irq}, 32'(m));
            wr(A_STAT, 32'hF);
        end

        // R4: match at wrap to zero
        wr(32'h04, 32'h0);
        wr(A_IE, 32'h2);
        wr(A_CNT, 32'hFFFFFFFF);
        tick(1);
        rd(A_STAT, v); chk("R4 match on wrap", v, 32'h2);
        wr(A_STAT, 32'hF);

        // R5: no re-arm while counter sits on compare value
        wr(A_IE, 32'h1);
        wr(32'h00, 32'd2000);
        wr(A_CNT, 32'd1999);
        tick(1);
        rd(A_STAT, v); chk("R5 first match", v, 32'h1);
        // R6: writing zero leaves the bit
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R6 write zero no effect", v, 32'h1);
        wr(A_STAT, 32'h1);
        repeat (3) @(negedge clk);
        rd(A_STAT, v); chk("R5 no repeat without tick", v, 32'h0);

        // R6: clear and match in same cycle -> match wins
        wr(A_CNT, 32'd1999);
        @(negedge clk);
        wr_en = 1; addr = A_STAT; wdata = 32'h1; tick_en = 1;
        @(negedge clk);
        wr_en = 0; tick_en = 0;
        rd(A_STAT, v); chk("R6 match beats clear", v, 32'h1);
        wr(A_STAT, 32'h1);
        rd(A_STAT, v); chk("R6 clear works", v, 32'h0);

        // R8: arm register behaviour
        rd(A_WD, v); chk("R8 disarmed at start", v, 32'h0);
        wr(A_WD, 32'h0);
        rd(A_WD, v); chk("R8 write zero no set", v, 32'h0);
        wr(A_WD, 32'hFFFFFFFF);
        rd(A_WD, v); chk("R8 set, upper zero", v, 32'h1);
        wr(A_WD, 32'h0);
        rd(A_WD, v); chk("R8 zero cannot clear", v, 32'h1);

        // R9: reset request pulse, with ie3 off
        wr(A_IE, 32'h0);
        wr(32'h0C, 32'd3000);
        wr(A_CNT, 32'd2998);
        tick(1);
        chk("R9 no request before match", {31'h0, rst_req}, 32'h0);
        tick(1);
        chk("R9 request pulse", {31'h0, rst_req}, 32'h1);
        @(negedge clk);
        chk("R9 pulse one cycle", {31'h0, rst_req}, 32'h0);
        rd(A_STAT, v); chk("R9 no status with ie3 off", v, 32'h0);

        // R8/R11: reset disarms; R9: no request when disarmed
        do_reset();
        rd(A_WD, v); chk("R8 reset clears arm", v, 32'h0);
        wr(32'h0C, 32'd3000);
        wr(A_CNT, 32'd2998);
        for (int k = 0; k < 2; k++) begin
            tick(1);
            chk("R9 disarmed no request", {31'h0, rst_req}, 32'h0);
        end
        @(negedge clk);
        chk("R9 disarmed no request later", {31'h0, rst_req}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule